// File: doc/BRIEF.md
# ATM Cell Header Check Byte Inserter

This block sits in the transmit byte path of a cell interface. It takes cells from a valid/ready byte source and hands them to a valid/ready byte sink. When insertion is on, each cell arrives as 52 bytes: four header bytes followed by 48 payload bytes. The block computes an 8-bit CRC over the four header bytes and places it in the cell as a fifth byte. The result is a 53-byte cell. The check byte can optionally be XORed with a fixed coset pattern. When insertion is off, 53-byte cells pass through untouched.

The check byte is emitted on the cycle after the last header byte. No cycle is lost on the output: while the check byte goes out, the block stalls the source for exactly one cycle. Back-pressure works like this. `out_ready` low freezes the byte on offer. Outside the check-byte slot, `in_ready` equals `out_ready`. The source must hold `in_data` steady while `in_valid` is high and `in_ready` is low. The sink sees `out_soc` on the first byte of each cell.

Top module: `hec_inserter`

## Requirements
- R1: The check byte is a CRC-8 with polynomial x^8+x^2+x+1 (0x07). Bits are processed most significant first, the start value is 0, and the CRC covers header bytes 0..3. It appears at output byte index 4, counting from 0.
- R2: The CRC starts from zero for every cell, so a cell's check byte never depends on an earlier cell or on a cell cut short by reset.
- R3: If `coset_en` was high at the cell's first byte, the inserted byte is the CRC XOR 0x55. Otherwise it is the raw CRC.
- R4: The check-byte slot is always offered with `out_valid` high, whatever `in_valid` does. With a source and sink that never stall, every cycle of a cell carries a valid output byte.
- R5: If `hec_en` was high at the cell's first byte, the block takes exactly 52 input bytes and gives 53 output bytes. Output bytes 0..3 are input bytes 0..3, and output bytes 5..52 are input bytes 4..51.
- R6: If `hec_en` was low at the cell's first byte, 53 input bytes are passed through unchanged and in order.
- R7: `in_ready` is low during the check-byte slot. At every other time it equals `out_ready`.
- R8: `out_soc` is high exactly when output byte index 0 of a cell is on offer with `out_valid`.
- R9: A synchronous reset on `rst` puts the block at the start of a cell. After reset, `out_valid` follows `in_valid` and the next byte taken is marked as a cell start.
- R10: `hec_en` and `coset_en` are sampled when byte 0 of a cell is transferred. Changes later in that cell have no effect on it.
- R11: While `out_ready` is low in the check-byte slot, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hec_en | input | 1 | Insert a check byte in cells that start while high |
| coset_en | input | 1 | XOR the check byte with 0x55 for cells that start while high |
| in_data | input | 8 | Source byte |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Block takes the source byte this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte this cycle |
| out_soc | output | 1 | Output byte is byte 0 of a cell |

## Verification
A wrong position count appears at the ports within one cell. `out_soc` lands on the wrong byte, `in_ready` drops at a position other than index 4, and the check byte shows up at a shifted index so that every payload byte after it mismatches. A residue that is not cleared, or is updated on a non-header byte, corrupts the very next check byte emitted. This fault is sharpest on all-zero headers, whose correct check byte is 0x00, or 0x55 with the coset. A mode sampled at the wrong moment changes cell length, so both streams drift out of step within the same cell.

// File: rtl/hec_pkg.sv
package hec_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic ins;
    logic coset;
  } cell_cfg_t;

  // One CRC-8 update over a full byte, most significant bit first.
  function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] res,
                                                   input logic [BYTE_W-1:0] din,
                                                   input logic [BYTE_W-1:0] poly);
    logic [BYTE_W-1:0] r;
    r = res;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (r[BYTE_W-1] ^ din[i]) r = (r << 1) ^ poly;
      else                      r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hec_pos_counter.sv
module hec_pos_counter #(
  parameter int CELL_BYTES = 53,
  localparam int PW = $clog2(CELL_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] LAST = PW'(CELL_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst)            pos <= '0;
    else if (adv) begin
      if (pos == LAST)  pos <= '0;
      else              pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/hec_crc_unit.sv
module hec_crc_unit
  import hec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              first,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] residue
);
  logic [BYTE_W-1:0] seed;

  // The first header byte starts from zero, so no cell inherits state.
  assign seed = first ? '0 : residue;

  always_ff @(posedge clk) begin
    if (rst)      residue <= '0;
    else if (upd) residue <= crc8_step(seed, din, POLY);
  end
endmodule

// File: rtl/hec_cell_cfg.sv
module hec_cell_cfg
  import hec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      capture,
  input  cell_cfg_t cfg_in,
  output cell_cfg_t cfg_out
);
  always_ff @(posedge clk) begin
    if (rst)          cfg_out <= '0;
    else if (capture) cfg_out <= cfg_in;
  end
endmodule

// File: rtl/hec_inserter.sv
module hec_inserter
  import hec_pkg::*;
#(
  parameter int                HDR_BYTES     = 4,
  parameter int                PAYLOAD_BYTES = 48,
  parameter logic [BYTE_W-1:0] POLY          = 8'h07,
  parameter logic [BYTE_W-1:0] COSET_PAT     = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hec_en,
  input  logic              coset_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_soc
);
  localparam int CELL_OUT = HDR_BYTES + 1 + PAYLOAD_BYTES;
  localparam int PW       = $clog2(CELL_OUT);
  localparam logic [PW-1:0] SLOT_POS = PW'(HDR_BYTES);

  logic [PW-1:0]     pos;
  logic              xfer, slot, at_first, in_header;
  cell_cfg_t         cfg_live, cfg_cell;
  logic [BYTE_W-1:0] residue, hec_byte;

  assign at_first  = (pos == '0);
  assign in_header = (pos < SLOT_POS);
  assign slot      = cfg_cell.ins && (pos == SLOT_POS);

  assign out_valid = slot | in_valid;
  assign in_ready  = out_ready & ~slot;
  assign hec_byte  = residue ^ (cfg_cell.coset ? COSET_PAT : '0);
  assign out_data  = slot ? hec_byte : in_data;
  assign out_soc   = out_valid & at_first;
  assign xfer      = out_valid & out_ready;

  assign cfg_live.ins   = hec_en;
  assign cfg_live.coset = coset_en;

  hec_pos_counter #(.CELL_BYTES(CELL_OUT)) u_pos (
    .clk (clk),
    .rst (rst),
    .adv (xfer),
    .pos (pos)
  );

  hec_cell_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .capture (xfer & at_first),
    .cfg_in  (cfg_live),
    .cfg_out (cfg_cell)
  );

  hec_crc_unit #(.POLY(POLY)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .upd     (xfer & in_header),
    .first   (at_first),
    .din     (in_data),
    .residue (residue)
  );
endmodule

// File: rtl/hec_inserter_chk.sv
module hec_inserter_chk #(
  parameter int HDR_BYTES = 4,
  parameter int CELL_OUT  = 53
) (
  input logic       clk,
  input logic       rst,
  input logic       hec_en,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_soc
);
  int   ocnt;
  logic mode_q;
  logic rst_q = 1'b0;
  logic slot;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      ocnt   <= 0;
      mode_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      if (ocnt == 0) mode_q <= hec_en;
      ocnt <= (ocnt == CELL_OUT - 1) ? 0 : ocnt + 1;
    end
  end

  assign slot = mode_q && (ocnt == HDR_BYTES);

  AST_SLOT_HOLDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    slot |-> (out_valid && !in_ready)); // R7

  AST_READY_FOLLOWS_SINK: assert property (@(posedge clk) disable iff (rst)
    !slot |-> (in_ready == out_ready)); // R7

  AST_SLOT_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (slot && !out_ready) |=> (out_valid && $stable(out_data))); // R11

  AST_SOC_AT_CELL_START: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_soc == (ocnt == 0))); // R8

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      AST_RESET_CELL_START: assert (!out_valid || out_soc); // R9
    end
  end
endmodule

bind hec_inserter hec_inserter_chk #(.HDR_BYTES(HDR_BYTES), .CELL_OUT(CELL_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hec_en    (hec_en),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_soc   (out_soc)
);

// File: tb/hec_inserter_tb.sv
module hec_inserter_tb;
  localparam int HDR = 4;
  localparam int OUTLEN = 53;
  localparam int MAXC = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hec_en = 1'b1, coset_en = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic       in_ready, out_valid, out_soc;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  hec_inserter u_dut (
    .clk(clk), .rst(rst), .hec_en(hec_en), .coset_en(coset_en),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_soc(out_soc)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit timeout = 0;
  int s_cell = 0, s_idx = 0, s_len = 52;
  bit s_pend = 0;
  int k_cell = 0, k_pos = 0;
  bit cfg_h [MAXC];
  bit cfg_c [MAXC];
  bit stall_prev = 0;
  logic [7:0] stall_data = '0;

  function automatic logic [7:0] gen(int c, int p);
    if (p < HDR && c % 5 == 1) return 8'h00;
    if (p < HDR && c % 5 == 2) return 8'hFF;
    return 8'(c * 29 + p * 13 + 7);
  endfunction

  function automatic logic [7:0] ref_hec(int c, bit cos);
    logic [7:0] r = 8'h00;
    for (int p = 0; p < HDR; p++) begin
      logic [7:0] b = gen(c, p);
      for (int i = 7; i >= 0; i--) begin
        if (r[7] ^ b[i]) r = (r << 1) ^ 8'h07;
        else             r = r << 1;
      end
    end
    return cos ? (r ^ 8'h55) : r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cell %0d byte %0d)",
               req, act, exp, k_cell, k_pos);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9", out_valid, 0);
    check(out_soc == 1'b0, "R9", out_soc, 0);
    check(in_ready == 1'b1, "R9", in_ready, 1);
    stall_prev = 0;
  endtask

  // vmode/rmode 0 = never stall; tog = toggle modes every few cycles (R10)
  task automatic run_phase(int ncells, int vmode, int rmode, bit tog,
                           int abort_at, string htag);
    int tgt = k_cell + ncells;
    while (k_cell < tgt && !timeout &&
           !(abort_at > 0 && k_cell == tgt - 1 && k_pos == abort_at)) begin
      logic [7:0] exp;
      string dtag;
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        timeout = 1;
        check(0, "watchdog", cyc, 150000);
        break;
      end
      if (tog) begin
        hec_en   = ((cyc >> 2) & 1) == 1;
        coset_en = ((cyc >> 3) & 1) == 1;
      end
      if (!s_pend) in_valid = (s_cell < tgt) && (vmode == 0 || cyc % 3 != 0);
      in_data   = gen(s_cell, s_idx);
      out_ready = (rmode == 0) || (cyc % 5 != 2);
      #1;
      if (stall_prev) begin
        check(out_valid == 1'b1, "R11", out_valid, 1);
        check(out_data == stall_data, "R11", out_data, stall_data);
      end
      if (k_pos == HDR && cfg_h[k_cell]) begin
        check(out_valid == 1'b1, "R4", out_valid, 1);
        check(in_ready == 1'b0, "R7", in_ready, 0);
      end else begin
        check(in_ready == out_ready, "R7", in_ready, out_ready);
      end
      if (vmode == 0 && rmode == 0 && !tog)
        check(out_valid == 1'b1, "R4", out_valid, 1);
      if (out_valid) check(out_soc == (k_pos == 0), "R8", out_soc, k_pos == 0);
      stall_prev = out_valid && !out_ready && k_pos == HDR && cfg_h[k_cell];
      stall_data = out_data;
      if (out_valid && out_ready) begin
        if (cfg_h[k_cell] || k_pos < HDR) begin
          if (k_pos < HDR)       begin exp = gen(k_cell, k_pos);     dtag = "R5"; end
          else if (k_pos == HDR) begin exp = ref_hec(k_cell, cfg_c[k_cell]); dtag = htag; end
          else                   begin exp = gen(k_cell, k_pos - 1); dtag = "R5"; end
        end else begin
          exp = gen(k_cell, k_pos); dtag = "R6";
        end
        check(out_data == exp, dtag, out_data, exp);
        k_pos++;
        if (k_pos == OUTLEN) begin k_pos = 0; k_cell++; end
      end
      if (in_valid && in_ready) begin
        if (s_idx == 0) begin
          cfg_h[s_cell] = hec_en;
          cfg_c[s_cell] = coset_en;
          s_len = hec_en ? 52 : 53;
        end
        s_idx++;
        if (s_idx == s_len) begin s_idx = 0; s_cell++; end
        s_pend = 0;
      end else begin
        s_pend = in_valid;
      end
    end
  endtask

  initial begin
    do_reset();
    hec_en = 1; coset_en = 0;
    run_phase(5, 0, 0, 0, 0, "R1");
    coset_en = 1;
    run_phase(5, 0, 0, 0, 0, "R3");
    hec_en = 0;
    run_phase(3, 0, 0, 0, 0, "R6");
    hec_en = 1;
    run_phase(5, 1, 1, 0, 0, "R3");
    // cut a cell short by reset, then verify a fresh residue
    coset_en = 0;
    run_phase(2, 1, 0, 0, 10, "R1");
    do_reset();
    s_idx = 0; s_pend = 0; k_pos = 0;
    s_cell = k_cell + 1; k_cell = s_cell;
    run_phase(3, 0, 0, 0, 0, "R2");
    run_phase(12, 1, 1, 1, 0, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule